// File: doc/BRIEF.md
# Serial register access slave

This block lets an external controller read and write an internal register bank over a serial link. The link has an active-low chip select, a serial clock and one data line in each direction. The block sits on a fast system clock. It passes all three serial pins through synchronizers and finds their edges. It decodes each frame and issues one-cycle strobes on a parallel register bus. The bus carries a 10-bit address, 8-bit write data and 8-bit read data.

A frame is only ever started by a falling edge of chip select. After that falling edge, the data line is taken in on each falling serial clock edge. The level of chip select no longer matters once the frame has begun. A finished write is held back and is committed on the next falling serial clock edge, which can be the first bit of the following frame. For a read, the register is fetched as soon as the address is complete. The value is then returned on the rising serial clock edges, led by a zero bit. The serial clock must stay in each level for at least three system clock periods.

Top module: `sra_slave`

## Requirements
- R1: A frame is, in arrival order: a start bit that must be 1, an operation bit (1 = read, 0 = write), 10 address bits MSB first and, for a write only, 8 data bits MSB first.
- R2: The data line is captured on falling serial clock edges and the output changes on rising edges. All outputs respond on the third system clock rising edge that samples the new pin level.
- R3: A write is not committed when its last data bit arrives. It is committed on the next falling serial clock edge, as a single-cycle `reg_wr` carrying the frame's address and data.
- R4: The held write commits on that following falling edge even when chip select is already high.
- R5: Frames may run back to back. The first falling serial clock edge of the next frame commits the previous write, and only the last frame of a burst needs a trailing clock.
- R6: In a write frame, clock edges after the 8th data bit start nothing and change nothing. Only the single commit strobe results.
- R7: In a read frame, one `reg_rd` pulse carrying the address is issued after the address LSB is captured. `reg_rdata` is sampled in the cycle that `reg_rd` is high.
- R8: On the first rising edge after the address LSB, `sdo` is 0 with `sdo_oe` high. The next 8 rising edges present the read byte MSB first, and the rising edge after those drops `sdo_oe`.
- R9: `sdo_oe` is low whenever no read bit is being presented or chip select is high. While `sdo_oe` is low, `sdo` is 0. Both are low after reset.
- R10: A falling chip select edge abandons any partial frame without a bus access and starts a new frame.
- R11: If the start bit is 0, every later bit is ignored until chip select falls again. No strobe is issued and `sdo_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |
| sdo_oe | output | 1 | Drive enable for sdo |
| reg_addr | output | 10 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data returned by the register bank in the reg_rd cycle |

## Verification
The hardest case to reach from the ports is a held write that is still pending when something else happens. Examples are a write that commits while chip select is high, a write that commits on the first bit of a following read frame, and a write that commits on surplus bits of its own frame. The stimulus builds bursts of frames in which chip select is raised and dropped between frames. It then reads the written registers back, so the order of commits becomes visible on the bus and on `sdo`. A behavioural model fed the same pin samples predicts every strobe and output bit in each cycle. This also covers the aborted frame and the bad start bit.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RECV = 2'd1,
    RX_DONE = 2'd2
  } rx_state_e;

  typedef enum logic [2:0] {
    FLD_START = 3'd0,
    FLD_OP    = 3'd1,
    FLD_ADDR  = 3'd2,
    FLD_DATA  = 3'd3,
    FLD_EXTRA = 3'd4
  } field_e;

  // Role of the bit at position idx within a frame.
  function automatic field_e field_of(input int idx, input int aw, input int dw);
    if (idx == 0)            return FLD_START;
    if (idx == 1)            return FLD_OP;
    if (idx < 2 + aw)        return FLD_ADDR;
    if (idx < 2 + aw + dw)   return FLD_DATA;
    return FLD_EXTRA;
  endfunction

  function automatic logic edge_rise(input logic now_lvl, input logic old_lvl);
    return now_lvl & ~old_lvl;
  endfunction

  function automatic logic edge_fall(input logic now_lvl, input logic old_lvl);
    return ~now_lvl & old_lvl;
  endfunction

endpackage

// File: rtl/sra_pin_sync.sv
module sra_pin_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);

  logic [STAGES-1:0][W-1:0] pipe;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], pins_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= pins_in;
      end
    end
  endgenerate

  assign lvl = pipe[STAGES-1];

  // One-cycle-delayed copy used for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= RST_VAL;
    else        prv <= lvl;
  end

endmodule

// File: rtl/sra_frame_rx.sv
module sra_frame_rx
  import sra_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              sclk_fall,
  input  logic              sdi_lvl,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata
);

  localparam int LAST_IDX = 1 + ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(LAST_IDX + 2);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(LAST_IDX);

  rx_state_e         st;
  logic [CNT_W-1:0]  bitcnt;
  logic              is_rd;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  // Named internal events
  field_e            fld;
  logic              take_bit;
  logic              commit_now;
  logic              bad_start;
  logic              addr_done;
  logic              data_done;
  logic [ADDR_W-1:0] addr_next;
  logic [DATA_W-1:0] data_next;

  assign fld        = field_of(int'(bitcnt), ADDR_W, DATA_W);
  assign take_bit   = sclk_fall && (st == RX_RECV) && !cs_fall;
  assign commit_now = sclk_fall && pend;
  assign bad_start  = take_bit && (fld == FLD_START) && !sdi_lvl;
  assign addr_next  = {addr_sh[ADDR_W-2:0], sdi_lvl};
  assign data_next  = {data_sh[DATA_W-2:0], sdi_lvl};
  assign addr_done  = take_bit && (fld == FLD_ADDR) && (bitcnt == ADDR_END);
  assign data_done  = take_bit && (fld == FLD_DATA) && (bitcnt == DATA_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      bitcnt    <= '0;
      is_rd     <= 1'b0;
      addr_sh   <= '0;
      data_sh   <= '0;
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;

      // Held write goes out on any falling serial clock edge.
      if (commit_now) begin
        reg_wr    <= 1'b1;
        reg_addr  <= pend_addr;
        reg_wdata <= pend_data;
        pend      <= 1'b0;
      end

      if (cs_fall) begin
        st     <= RX_RECV;
        bitcnt <= '0;
      end else if (take_bit) begin
        bitcnt <= bitcnt + 1'b1;
        unique case (fld)
          FLD_START: if (bad_start) st <= RX_DONE;
          FLD_OP:    is_rd <= sdi_lvl;
          FLD_ADDR: begin
            addr_sh <= addr_next;
            if (addr_done && is_rd) begin
              reg_rd   <= 1'b1;
              reg_addr <= addr_next;
              st       <= RX_DONE;
            end
          end
          FLD_DATA: begin
            data_sh <= data_next;
            if (data_done) begin
              pend      <= 1'b1;
              pend_addr <= addr_sh;
              pend_data <= data_next;
              st        <= RX_DONE;
            end
          end
          default: st <= RX_DONE;
        endcase
      end
    end
  end

  AST_WR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(sclk_fall)); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R3
  AST_RD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(sclk_fall)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R7
  AST_NO_ACCESS_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !$past(cs_fall)); // R10

endmodule

// File: rtl/sra_read_tx.sv
module sra_read_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_lvl,
  input  logic              sclk_rise,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int SH_W   = DATA_W + 1;
  localparam int OCNT_W = $clog2(SH_W + 1);
  localparam logic [OCNT_W-1:0] OCNT_END = OCNT_W'(SH_W);

  logic              armed,    armed_n;
  logic              shifting, shifting_n;
  logic [OCNT_W-1:0] ocnt,     ocnt_n;
  logic [SH_W-1:0]   shreg,    shreg_n;
  logic              cur_bit,  cur_bit_n;

  // Named internal events
  logic load_evt;
  logic step_evt;
  logic stop_evt;

  assign load_evt = !cs_fall && rd_stb;
  assign step_evt = !cs_fall && !rd_stb && sclk_rise && armed && (ocnt < OCNT_END);
  assign stop_evt = !cs_fall && !rd_stb && sclk_rise && armed && (ocnt == OCNT_END);

  always_comb begin
    armed_n    = armed;
    shifting_n = shifting;
    ocnt_n     = ocnt;
    shreg_n    = shreg;
    cur_bit_n  = cur_bit;
    if (cs_fall) begin
      armed_n    = 1'b0;
      shifting_n = 1'b0;
    end else if (load_evt) begin
      shreg_n    = {1'b0, rdata};
      armed_n    = 1'b1;
      shifting_n = 1'b0;
      ocnt_n     = '0;
    end else if (step_evt) begin
      cur_bit_n  = shreg[SH_W-1];
      shreg_n    = {shreg[SH_W-2:0], 1'b0};
      shifting_n = 1'b1;
      ocnt_n     = ocnt + 1'b1;
    end else if (stop_evt) begin
      armed_n    = 1'b0;
      shifting_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      shifting <= 1'b0;
      ocnt     <= '0;
      shreg    <= '0;
      cur_bit  <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      armed    <= armed_n;
      shifting <= shifting_n;
      ocnt     <= ocnt_n;
      shreg    <= shreg_n;
      cur_bit  <= cur_bit_n;
      sdo_oe   <= shifting_n & ~cs_lvl;
      sdo      <= shifting_n & ~cs_lvl & cur_bit_n;
    end
  end

  AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sclk_rise)); // R8
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo); // R8
  AST_SDO_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $past(sclk_rise)); // R2
  AST_OE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(armed)); // R9

endmodule

// File: rtl/sra_slave.sv
module sra_slave
  import sra_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDI  = 2;
  localparam int NPINS    = 3;
  // Idle levels: chip select and serial clock high, data low.
  localparam logic [NPINS-1:0] PIN_IDLE = 3'b011;

  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] pin_prv;

  sra_pin_sync #(
    .W       (NPINS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_in ({sdi, sclk, cs_n}),
    .lvl     (pin_lvl),
    .prv     (pin_prv)
  );

  // Named edge events shared by the frame and output logic
  logic cs_lvl, cs_fall, sclk_rise, sclk_fall, sdi_lvl, sdi_prv;

  assign cs_lvl    = pin_lvl[PIN_CS];
  assign cs_fall   = edge_fall(pin_lvl[PIN_CS],   pin_prv[PIN_CS]);
  assign sclk_rise = edge_rise(pin_lvl[PIN_SCLK], pin_prv[PIN_SCLK]);
  assign sclk_fall = edge_fall(pin_lvl[PIN_SCLK], pin_prv[PIN_SCLK]);
  assign sdi_lvl   = pin_lvl[PIN_SDI];
  assign sdi_prv   = pin_prv[PIN_SDI];

  sra_frame_rx #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .sclk_fall (sclk_fall),
    .sdi_lvl   (sdi_lvl),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

  sra_read_tx #(
    .DATA_W (DATA_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .cs_lvl    (cs_lvl),
    .sclk_rise (sclk_rise),
    .rd_stb    (reg_rd),
    .rdata     (reg_rdata),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  AST_SDI_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |-> (sdi_lvl == sdi_prv)); // R2
  AST_OE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !$past(cs_n, 3)); // R9

endmodule

// File: tb/sra_slave_tb.sv
module sra_slave_tb;

  localparam int H = 6;  // serial half period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic       sdo, sdo_oe, reg_wr, reg_rd;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  sra_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int checks = 0, failures = 0, wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  bit reported = 0;
  logic [9:0] last_rd_addr;

  function automatic logic [7:0] init_byte(input int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  // Register bank seen by the DUT
  logic [7:0] bus_mem [0:1023];
  assign reg_rdata = bus_mem[reg_addr];
  initial for (int i = 0; i < 1024; i++) bus_mem[i] = init_byte(i);
  always @(posedge clk) if (rst_n && reg_wr) bus_mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic wr, rd, oe, sdo;
    logic [9:0] addr;
    logic [7:0] wdat;
  } snap_t;

  snap_t h0, h1, h2, m;
  logic [7:0] m_mem [0:1023];
  initial for (int i = 0; i < 1024; i++) m_mem[i] = init_byte(i);
  logic p_cs, p_sc;
  int   m_st, m_cnt, m_ocnt;
  logic m_op, m_pend, m_armed, m_shift, m_bit;
  logic [9:0] m_addr, m_paddr;
  logic [7:0] m_data, m_pdata;
  logic [8:0] m_sh;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_cs = 1; p_sc = 1; m_st = 0; m_cnt = 0; m_ocnt = 0; m_op = 0;
      m_pend = 0; m_armed = 0; m_shift = 0; m_bit = 0; m_addr = 0;
      m_data = 0; m_paddr = 0; m_pdata = 0; m_sh = 0;
      h0 = '0; h1 = '0; h2 = '0;
    end else begin
      logic csf, scf, scr, d, c;
      c = cs_n; d = sdi;
      csf = p_cs && !cs_n;
      scf = p_sc && !sclk;
      scr = !p_sc && sclk;
      p_cs = cs_n; p_sc = sclk;
      m = '0;
      if (scf && m_pend) begin
        m.wr = 1; m.addr = m_paddr; m.wdat = m_pdata;
        m_mem[m_paddr] = m_pdata; m_pend = 0;
      end
      if (csf) begin
        m_st = 1; m_cnt = 0;
      end else if (scf && m_st == 1) begin
        int idx;
        idx = m_cnt; m_cnt++;
        if (idx == 0) begin
          if (!d) m_st = 2;
        end else if (idx == 1) m_op = d;
        else if (idx <= 11) begin
          m_addr = {m_addr[8:0], d};
          if (idx == 11 && m_op) begin m.rd = 1; m.addr = m_addr; m_st = 2; end
        end else begin
          m_data = {m_data[6:0], d};
          if (idx == 19) begin m_pend = 1; m_paddr = m_addr; m_pdata = m_data; m_st = 2; end
        end
      end
      if (csf) begin
        m_armed = 0; m_shift = 0;
      end else if (m.rd) begin
        m_sh = {1'b0, m_mem[m.addr]}; m_armed = 1; m_ocnt = 0; m_shift = 0;
      end else if (scr && m_armed) begin
        if (m_ocnt < 9) begin
          m_bit = m_sh[8]; m_sh = {m_sh[7:0], 1'b0}; m_shift = 1; m_ocnt++;
        end else begin
          m_armed = 0; m_shift = 0;
        end
      end
      m.oe  = m_shift && !c;
      m.sdo = m.oe && m_bit;
      h2 = h1; h1 = h0; h0 = m;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !reported) begin
      string tag;
      bit ok;
      ok = 1; tag = "R2";
      if (reg_wr !== h2.wr || (h2.wr && (reg_addr !== h2.addr || reg_wdata !== h2.wdat))) begin
        ok = 0; tag = "R3 wr";
      end
      if (reg_rd !== h2.rd || (h2.rd && reg_addr !== h2.addr)) begin
        ok = 0; tag = "R7 rd";
      end
      if (sdo_oe !== h2.oe || sdo !== h2.sdo) begin
        ok = 0; tag = "R8 sdo/oe";
      end
      check(ok, tag, {reg_wr, reg_rd, sdo_oe, sdo}, {h2.wr, h2.rd, h2.oe, h2.sdo});
      if (reg_wr) wr_cnt++;
      if (reg_rd) begin rd_cnt++; last_rd_addr = reg_addr; end
      if (sdo_oe) oe_cnt++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdi = b; idle(H); sclk = 0; idle(H); sclk = 1;
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(w[i]);
  endtask

  task automatic frame_begin();
    if (cs_n == 1'b0) begin cs_n = 1; idle(H); end
    cs_n = 0; idle(H);
  endtask

  task automatic frame_end();
    idle(2); cs_n = 1; idle(H);
  endtask

  task automatic write_frame(input logic [9:0] a, input logic [7:0] dv);
    frame_begin();
    send_word({12'h0, 2'b10, a, dv}, 20);
    frame_end();
  endtask

  task automatic read_frame(input logic [9:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    frame_begin();
    send_word({20'h0, 2'b11, a}, 12);
    idle(4);
    check(sdo_oe === 1'b1 && sdo === 1'b0, "R8 leading zero", {sdo_oe, sdo}, 2'b10);
    for (int i = 7; i >= 0; i--) begin
      idle(H - 4); sclk = 0; idle(H); sclk = 1; idle(4);
      got[i] = sdo;
      if (sdo_oe !== 1'b1) check(0, "R8 oe during data", sdo_oe, 1);
    end
    check(got === exp, tag, got, exp);
    idle(H - 4); sclk = 0; idle(H); sclk = 1; idle(4);
    check(sdo_oe === 1'b0 && sdo === 1'b0, "R8 oe drop after byte", {sdo_oe, sdo}, 0);
    frame_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int w0, r0, o0;
    idle(4); rst_n = 1; idle(5);
    // R9: reset state
    check(sdo_oe === 0 && sdo === 0 && reg_wr === 0 && reg_rd === 0, "R9 reset",
          {sdo_oe, sdo, reg_wr, reg_rd}, 0);

    // R3/R4: write held until an extra falling edge with chip select high
    write_frame(10'h155, 8'hA3);
    idle(20);
    check(wr_cnt == 0, "R3 no commit at last bit", wr_cnt, 0);
    check(bus_mem[10'h155] == init_byte(10'h155), "R3 register untouched", bus_mem[10'h155], init_byte(10'h155));
    bit_out(1'b0);
    idle(6);
    check(wr_cnt == 1, "R4 commit with cs high", wr_cnt, 1);
    check(bus_mem[10'h155] == 8'hA3, "R1 R3 written value", bus_mem[10'h155], 8'hA3);

    // R5: back-to-back frames, no gap clock
    write_frame(10'h3FF, 8'h5C);
    check(wr_cnt == 1, "R5 first frame held", wr_cnt, 1);
    write_frame(10'h001, 8'h77);
    check(wr_cnt == 2 && bus_mem[10'h3FF] == 8'h5C, "R5 commit on next frame", bus_mem[10'h3FF], 8'h5C);
    check(bus_mem[10'h001] == init_byte(1), "R5 second still held", bus_mem[10'h001], init_byte(1));
    r0 = rd_cnt;
    read_frame(10'h3FF, 8'h5C, "R8 read data 3FF");
    check(bus_mem[10'h001] == 8'h77, "R5 commit on read frame", bus_mem[10'h001], 8'h77);

    // R7: one read strobe with the address
    read_frame(10'h001, 8'h77, "R8 read data 001");
    check(rd_cnt == r0 + 2 && last_rd_addr == 10'h001, "R7 read strobe", last_rd_addr, 10'h001);

    // R6: surplus bits after a write
    w0 = wr_cnt;
    frame_begin();
    send_word({8'h0, 2'b10, 10'h0AA, 8'h3C, 4'hF}, 24);
    frame_end();
    idle(6);
    check(wr_cnt == w0 + 1, "R6 one strobe only", wr_cnt, w0 + 1);
    check(bus_mem[10'h0AA] == 8'h3C, "R6 value kept", bus_mem[10'h0AA], 8'h3C);
    check(bus_mem[10'h2AF] == init_byte(10'h2AF), "R6 no stray write", bus_mem[10'h2AF], init_byte(10'h2AF));

    // R10: partial frame abandoned by a new chip select fall
    w0 = wr_cnt; r0 = rd_cnt;
    frame_begin();
    send_word({25'h0, 7'b1101010}, 7);
    check(wr_cnt == w0 && rd_cnt == r0, "R10 no access from partial", wr_cnt, w0);
    write_frame(10'h020, 8'h99);
    bit_out(1'b0);
    idle(6);
    check(wr_cnt == w0 + 1 && bus_mem[10'h020] == 8'h99, "R10 restart frame", bus_mem[10'h020], 8'h99);

    // R11: bad start bit
    w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
    frame_begin();
    send_word({12'h0, 20'h7FFFF}, 20);
    frame_end();
    bit_out(1'b0);
    idle(6);
    check(wr_cnt == w0 && rd_cnt == r0, "R11 no strobe", wr_cnt + rd_cnt, w0 + r0);
    check(oe_cnt == o0, "R11 R9 output stays off", oe_cnt, o0);
    read_frame(10'h020, 8'h99, "R11 recovery read");
    read_frame(10'h2AF, init_byte(10'h2AF), "R1 untouched register");

    idle(10);
    report();
  end

endmodule